// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block gathers interrupt requests from four counter channels, picks among them by fixed priority, and joins an external priority chain made of an enable input from the higher-priority neighbour and an enable output to lower-priority devices. A channel's zero-count event, when that channel's interrupt enable is set, makes the channel pending. While anything is pending and the chain grants this block priority, it pulls a shared active-low request line.

When the processor acknowledges, the block takes the highest-priority pending channel into service and returns a vector made from a programmable base with the channel number placed in bits [2:1] and bit 0 cleared. While a channel is pending or in service, the enable output stays low so that devices further down the chain cannot interrupt. A return-from-interrupt strobe ends the service. Requests that come in meanwhile stay pending and are presented after the service ends.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset nothing is pending or in service: int_n_o is 1, vec_valid_o is 0 and ieo_o equals iei_i.
- R2: A bit of chan_evt_i whose chan_ien_i bit is 1 makes that channel pending from the next clock edge; an event whose enable bit is 0 is ignored and leaves int_n_o at 1 and ieo_o equal to iei_i.
- R3: int_n_o is 0 exactly when at least one channel is pending, iei_i is 1 and no channel is in service.
- R4: ieo_o equals iei_i when no channel is pending or in service, and is 0 otherwise.
- R5: An ack_i pulse while int_n_o is 0 puts the lowest-numbered pending channel (channel 0 highest) in service and clears its pending bit; in the next cycle vec_valid_o is 1 for one cycle and vec_o equals vec_base_i with bits [2:1] replaced by the channel number and bit 0 forced to 0.
- R6: An ack_i pulse while iei_i is 0, while a channel is in service, or with nothing pending is ignored: vec_valid_o stays 0 and the pending and service state is unchanged.
- R7: A reti_i pulse clears the in-service state at the next edge; ieo_o then follows iei_i again if nothing is pending.
- R8: A request arriving while another channel is in service stays pending, keeps int_n_o at 1 during the service, and is offered after reti_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_evt_i | input | 4 | Per-channel zero-count event pulses |
| chan_ien_i | input | 4 | Per-channel interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| iei_i | input | 1 | Priority enable from higher-priority neighbour |
| vec_base_i | input | 8 | Programmable vector base |
| int_n_o | output | 1 | Shared interrupt request, active low |
| ieo_o | output | 1 | Priority enable to lower-priority devices |
| vec_o | output | 8 | Vector of the channel taken into service |
| vec_valid_o | output | 1 | One-cycle strobe marking vec_o valid |

## Verification
A lost or stuck pending bit shows at the ports in the cycle after the event, as int_n_o or ieo_o disagreeing with the expected level, and a wrong winner shows in vec_o one cycle after the acknowledge. A stuck in-service flag shows as ieo_o held low and int_n_o held high after a return-from-interrupt, visible in the very next cycle. Random mixes of events, enables, acknowledges, returns and chain enable levels are run against a bench model alongside directed priority and blocking cases.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   // Which end of the channel vector wins arbitration
   typedef enum logic {
      ORDER_LOW_WINS  = 1'b0,
      ORDER_HIGH_WINS = 1'b1
   } prio_order_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic [NUM_CH-1:0] ien,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] pend
);
   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend[g] <= 1'b0;
            else if (evt[g] && ien[g])
               pend[g] <= 1'b1;
            else if (clr[g])
               pend[g] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_chain_pkg::*;
#(
   parameter int          NUM_CH = 4,
   parameter prio_order_e ORDER  = ORDER_LOW_WINS,
   localparam int         CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] win_oh,
   output logic [CH_W-1:0]   win_idx,
   output logic              any
);
   assign any = |req;

   generate
      if (ORDER == ORDER_LOW_WINS) begin : g_low
         always_comb begin
            win_oh  = '0;
            win_idx = '0;
            for (int i = NUM_CH - 1; i >= 0; i--) begin
               if (req[i]) begin
                  win_oh  = '0;
                  win_oh[i] = 1'b1;
                  win_idx = CH_W'(i);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            win_oh  = '0;
            win_idx = '0;
            for (int i = 0; i < NUM_CH; i++) begin
               if (req[i]) begin
                  win_oh  = '0;
                  win_oh[i] = 1'b1;
                  win_idx = CH_W'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
   parameter int  NUM_CH = 4,
   parameter int  VEC_W  = 8,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [NUM_CH-1:0] win_oh,
   input  logic [CH_W-1:0]   win_idx,
   input  logic              reti,
   input  logic [VEC_W-1:0]  base,
   output logic              busy,
   output logic [VEC_W-1:0]  vec,
   output logic              vec_valid
);
   logic [NUM_CH-1:0] ins_q;
   logic [VEC_W-1:0]  vec_d;

   always_comb begin
      vec_d           = base;
      vec_d[CH_W:1]   = win_idx;
      vec_d[0]        = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_q     <= '0;
         vec       <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= take;
         if (take) begin
            ins_q <= win_oh;
            vec   <= vec_d;
         end else if (reti) begin
            ins_q <= '0;
         end
      end
   end

   assign busy = |ins_q;
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
   import irq_chain_pkg::*;
#(
   parameter int          NUM_CH = 4,
   parameter int          VEC_W  = 8,
   parameter prio_order_e ORDER  = ORDER_LOW_WINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] chan_evt_i,
   input  logic [NUM_CH-1:0] chan_ien_i,
   input  logic              ack_i,
   input  logic              reti_i,
   input  logic              iei_i,
   input  logic [VEC_W-1:0]  vec_base_i,
   output logic              int_n_o,
   output logic              ieo_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_valid_o
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (VEC_W <= CH_W) begin : g_bad_vec
         $error("VEC_W must exceed the channel index width");
      end
   endgenerate

   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] win_oh;
   logic [NUM_CH-1:0] clr;
   logic [CH_W-1:0]   win_idx;
   logic              any_pend;
   logic              busy;
   logic              take;

   assign take = ack_i && iei_i && any_pend && !busy;
   assign clr  = take ? win_oh : '0;

   irq_req_latch #(.NUM_CH(NUM_CH)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (chan_evt_i),
      .ien  (chan_ien_i),
      .clr  (clr),
      .pend (pend)
   );

   irq_prio_pick #(.NUM_CH(NUM_CH), .ORDER(ORDER)) u_pick (
      .req    (pend),
      .win_oh (win_oh),
      .win_idx(win_idx),
      .any    (any_pend)
   );

   irq_svc_track #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .win_oh   (win_oh),
      .win_idx  (win_idx),
      .reti     (reti_i),
      .base     (vec_base_i),
      .busy     (busy),
      .vec      (vec_o),
      .vec_valid(vec_valid_o)
   );

   assign int_n_o = !(any_pend && iei_i && !busy);
   assign ieo_o   = iei_i && !any_pend && !busy;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
   parameter int NUM_CH = 4,
   parameter int VEC_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             iei_i,
   input logic             int_n_o,
   input logic             ieo_o,
   input logic [VEC_W-1:0] vec_o,
   input logic             vec_valid_o
);
   // R4
   ieo_follows_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iei_i |-> !ieo_o);
   // R3
   req_needs_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_n_o |-> iei_i);
   // R4
   req_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_n_o |-> !ieo_o);
   // R5
   vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !int_n_o) |=> vec_valid_o);
   // R6
   no_vec_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_i || int_n_o) |=> !vec_valid_o);
   // R5
   vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (vec_o[0] == 1'b0));
   // R8
   served_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (int_n_o && !ieo_o));
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_i      (ack_i),
   .iei_i      (iei_i),
   .int_n_o    (int_n_o),
   .ieo_o      (ieo_o),
   .vec_o      (vec_o),
   .vec_valid_o(vec_valid_o)
);

// File: tb/sim_irq_chain_ctrl.sv
`timescale 1ns/1ps
module sim_irq_chain_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] evt = '0, ien = '0;
   logic       ack = 1'b0, reti = 1'b0, iei = 1'b1;
   logic [7:0] base = 8'hA0;
   logic       int_n, ieo, vvalid;
   logic [7:0] vec;

   int checks = 0, fails = 0;
   logic [3:0] m_pend = '0, m_ins = '0;
   logic [7:0] m_vec = '0;
   logic       m_vv = 1'b0;

   always #2 clk = ~clk;

   irq_chain_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .chan_evt_i(evt), .chan_ien_i(ien),
      .ack_i(ack), .reti_i(reti), .iei_i(iei), .vec_base_i(base),
      .int_n_o(int_n), .ieo_o(ieo), .vec_o(vec), .vec_valid_o(vvalid)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int lowest(logic [3:0] p);
      for (int i = 3; i >= 0; i--) if (p[i]) lowest = i;
      if (p == 0) lowest = 0;
   endfunction

   function automatic logic [7:0] mkvec(logic [7:0] b, int ch);
      logic [7:0] v = b;
      v[2:1] = ch[1:0];
      v[0] = 1'b0;
      return v;
   endfunction

   // Advance the model by one edge using the inputs in place now
   task automatic model_edge();
      logic grant;
      int   w;
      grant = ack && iei && (m_pend != 0) && (m_ins == 0);
      w = lowest(m_pend);
      m_vv = grant;
      if (grant) begin
         m_vec = mkvec(base, w);
         m_pend[w] = 1'b0;
         m_ins = 4'b1 << w;
      end else if (reti) begin
         m_ins = '0;
      end
      m_pend = m_pend | (evt & ien);
   endtask

   task automatic check_all();
      check("R3 int_n", int_n, !((m_pend != 0) && iei && (m_ins == 0)));
      check("R4 ieo", ieo, iei && (m_pend == 0) && (m_ins == 0));
      check("R5/R6 vec_valid", vvalid, m_vv);
      if (m_vv) check("R5 vec", vec, m_vec);
   endtask

   // Inputs are set after a falling edge; one rising edge; sample 1 ns later
   task automatic step(logic [3:0] e, logic [3:0] en, logic a, logic r, logic ci);
      @(negedge clk);
      evt = e; ien = en; ack = a; reti = r; iei = ci;
      @(posedge clk);
      model_edge();
      #1;
      check_all();
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 int_n", int_n, 1);
      check("R1 ieo", ieo, 1);
      check("R1 vec_valid", vvalid, 0);

      // R2 event without enable ignored
      step(4'b0001, 4'b0000, 0, 0, 1);
      check("R2 ignored int_n", int_n, 1);
      check("R2 ignored ieo", ieo, 1);
      // R2 enabled events on channels 1 and 2
      step(4'b0110, 4'b1111, 0, 0, 1);
      check("R2 pending int_n", int_n, 0);
      // R6 ack with chain enable low
      step(4'b0000, 4'b1111, 1, 0, 0);
      check("R6 no vec", vvalid, 0);
      check("R6 ieo low", ieo, 0);
      // R5 ack picks channel 1
      step(4'b0000, 4'b1111, 1, 0, 1);
      check("R5 vec ch1", vec, 8'hA2);
      check("R5 valid", vvalid, 1);
      // R8 channel 0 arrives during service
      step(4'b0001, 4'b1111, 0, 0, 1);
      check("R8 held int_n", int_n, 1);
      step(4'b0000, 4'b1111, 1, 0, 1);
      check("R6 ack while busy", vvalid, 0);
      // R7 return releases; channel 0 wins over channel 2
      step(4'b0000, 4'b1111, 0, 1, 1);
      check("R7 int_n after reti", int_n, 0);
      step(4'b0000, 4'b1111, 1, 0, 1);
      check("R8 vec ch0", vec, 8'hA0);
      step(4'b0000, 4'b1111, 0, 1, 1);
      step(4'b0000, 4'b1111, 1, 0, 1);
      check("R5 vec ch2", vec, 8'hA4);
      step(4'b0000, 4'b1111, 0, 1, 1);
      check("R7 ieo released", ieo, 1);
      base = 8'h5F;
      step(4'b1000, 4'b1000, 0, 0, 1);
      step(4'b0000, 4'b0000, 1, 0, 1);
      check("R5 vec ch3", vec, 8'h5E);
      step(4'b0000, 4'b0000, 0, 1, 1);

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         if ((n % 97) == 0) base = 8'($urandom);
         step(4'($urandom) & 4'($urandom),
              4'($urandom) | 4'($urandom),
              ($urandom % 3) == 0,
              ($urandom % 4) == 0,
              ($urandom % 6) != 0);
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule